// File: doc/BRIEF.md
# Keyed-Disable Watchdog Timer

This block is a watchdog timer. It comes out of any reset already counting down from a reload value. When the count runs out, it raises a one-cycle reset request. Software stops it only by writing an ordered pair of key words to a single stop register. A register that is cleared or set with one write cannot stop it.

Each write to the stop register takes a fixed number of cycles to take effect. This models the hand-off into a slow counter clock. A pending flag is visible while the write is in flight, and key writes made during that time are dropped. A soft-reset request re-arms the timer, and a done flag reports when the soft reset has finished.

Access uses single-cycle read and write strobes with byte addresses. Reads are combinational: `rdata_o` is valid in the same cycle as `rd_en_i` and is zero otherwise.

Top module: `wdt_keyed`

## Requirements
- R1: After `rst_ni` is released, the timer is enabled. The counter starts at `LOAD_RST`, so the first `expire_o` pulse follows the `LOAD_RST+1`-th rising clock edge after release.
- R2: When the counter is at zero while enabled, the next edge raises `expire_o` for exactly one cycle and reloads the counter. While the timer stays enabled, pulses repeat every load+1 cycles.
- R3: After the word 0x0000AAAA and then the word 0x00005555 have each been posted to the stop register (byte offset 0x48), the counter holds its value and `expire_o` stays low.
- R4: The pending register (offset 0x34) reads 0x10 (bit 4 set, all other bits 0) for exactly `POST_CYC` cycles, starting with the cycle after a stop-register write edge. Otherwise it reads 0.
- R5: A stop-register write made while bit 4 of the pending register is set is dropped. It affects neither the key sequence nor the counter.
- R6: If a posted word other than 0x0000AAAA follows 0x0000AAAA, the key sequence returns to its start. A 0x00005555 that is not preceded by 0x0000AAAA has no effect. A repeated 0x0000AAAA keeps the first step. In each of these cases the timer stays enabled.
- R7: Writing a word with bit 1 set to the control register (offset 0x10) starts a soft reset. Bit 0 of the status register (offset 0x14) then reads 0 for `SRST_CYC` cycles, and reads 1 otherwise. When the soft reset completes, the timer is enabled, the counter equals the load value, and the key sequence and the posting are cleared.
- R8: The load register (offset 0x2C) is read/write and resets to `LOAD_RST`. Every reload and every re-arm takes its value from this register.
- R9: The count register (offset 0x28) reads the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, combinational |
| expire_o | output | 1 | One-cycle reset request on expiry |

## Verification
All results are checked at the cycle they are due, as follows:
- Read data is sampled in the same cycle as the read strobe, on the falling edge.
- The pending flag first reads set in the cycle after the write edge. The bench counts set cycles until the flag clears and compares the total with `POST_CYC`.
- The done flag reads low for `SRST_CYC` cycles, counted from the cycle after the control write.
- In the next cycle the counter must read load-1.
- Expiry pulses are timed by counting rising edges between pulses, which must equal load+1.

A stopped or running timer is judged from two count reads taken a few cycles apart.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SCTL = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_LOAD = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_PEND = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h48;

  localparam int unsigned SRST_BIT = 1;
  localparam int unsigned DONE_BIT = 0;
  localparam int unsigned PEND_BIT = 4;

  localparam logic [15:0] KEY_A = 16'hAAAA;
  localparam logic [15:0] KEY_B = 16'h5555;

  typedef enum logic {KS_IDLE, KS_HALF} key_st_e;
endpackage

// File: rtl/wdt_post.sv
module wdt_post #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned POST_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              pend_o,
  output logic              apply_o,
  output logic [DATA_W-1:0] val_o
);
  localparam int unsigned PW = $clog2(POST_CYC + 1);

  logic [PW-1:0]     cnt_q;
  logic [DATA_W-1:0] val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      val_q <= '0;
    end else if (flush_i) begin
      cnt_q <= '0;
    end else if (we_i && cnt_q == '0) begin
      cnt_q <= PW'(POST_CYC);
      val_q <= wdata_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign pend_o  = (cnt_q != '0);
  assign apply_o = (cnt_q == PW'(1)) && !flush_i;
  assign val_o   = val_q;

  // a write arriving mid-post must not disturb the word in flight
  p_post_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !flush_i) |=> $stable(val_q));
endmodule

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm import wdt_keyed_pkg::*; #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              apply_i,
  input  logic [DATA_W-1:0] val_i,
  output key_st_e           st_o,
  output logic              stop_o
);
  key_st_e st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            st_q <= KS_IDLE;
    else if (clr_i)                         st_q <= KS_IDLE;
    else if (apply_i && val_i == DATA_W'(KEY_A)) st_q <= KS_HALF;
    else if (apply_i)                       st_q <= KS_IDLE;
  end

  assign st_o   = st_q;
  assign stop_o = apply_i && !clr_i && st_q == KS_HALF && val_i == DATA_W'(KEY_B);
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned LOAD_RST = 'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             hold_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             en_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             en_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(LOAD_RST);
      en_q  <= 1'b1;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (restart_i) begin
        cnt_q <= load_i;
        en_q  <= 1'b1;
      end else if (stop_i) begin
        en_q <= 1'b0;
      end else if (en_q && !hold_i) begin
        if (cnt_q == '0) begin
          exp_q <= 1'b1;
          cnt_q <= load_i;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign en_o     = en_q;
  assign expire_o = exp_q;

  p_hold_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !restart_i) |=> ($stable(cnt_q) && !exp_q));

  p_expire_reload_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q |-> (cnt_q == $past(load_i)));
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed import wdt_keyed_pkg::*; #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned LOAD_RST = 'hFFFF,
  parameter int unsigned POST_CYC = 4,
  parameter int unsigned SRST_CYC = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              expire_o
);
  localparam int unsigned SW = $clog2(SRST_CYC + 1);

  logic [SW-1:0]     srst_q;
  logic [CNT_W-1:0]  load_q, cnt;
  logic [DATA_W-1:0] post_val;
  logic              busy, restart, key_we, srst_we, load_we;
  logic              pend, apply, stop, en;
  key_st_e           key_st;

  assign busy    = (srst_q != '0);
  assign restart = (srst_q == SW'(1));
  assign key_we  = wr_en_i && addr_i == OFS_KEY && !busy;
  assign srst_we = wr_en_i && addr_i == OFS_SCTL && wdata_i[SRST_BIT] && !busy;
  assign load_we = wr_en_i && addr_i == OFS_LOAD;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          srst_q <= '0;
    else if (srst_we)     srst_q <= SW'(SRST_CYC);
    else if (busy)        srst_q <= srst_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      load_q <= CNT_W'(LOAD_RST);
    else if (load_we) load_q <= wdata_i[CNT_W-1:0];
  end

  wdt_post #(.DATA_W(DATA_W), .POST_CYC(POST_CYC)) u_post (
    .clk_i, .rst_ni, .flush_i(busy), .we_i(key_we), .wdata_i,
    .pend_o(pend), .apply_o(apply), .val_o(post_val)
  );

  wdt_key_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i, .rst_ni, .clr_i(busy), .apply_i(apply), .val_i(post_val),
    .st_o(key_st), .stop_o(stop)
  );

  wdt_count #(.CNT_W(CNT_W), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk_i, .rst_ni, .restart_i(restart), .hold_i(busy), .stop_i(stop),
    .load_i(load_q), .cnt_o(cnt), .en_o(en), .expire_o
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      case (addr_i)
        OFS_STAT: rdata_o[DONE_BIT] = !busy;
        OFS_PEND: rdata_o[PEND_BIT] = pend;
        OFS_CNT:  rdata_o = DATA_W'(cnt);
        OFS_LOAD: rdata_o = DATA_W'(load_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  // the timer may only go quiet on the second key of an ordered pair
  p_stop_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en) |-> ($past(key_st) == KS_HALF && $past(apply)));

  p_rearm_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(busy) && $stable(load_q)) |-> (en && cnt == load_q && key_st == KS_IDLE));
endmodule

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
  localparam int unsigned LOAD = 40;
  localparam int unsigned POST = 4;
  localparam int unsigned SRST = 3;

  logic        clk = 0, rst_ni = 0, wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        expire;
  int          checks = 0, errors = 0;
  int unsigned cur_load = LOAD;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  bit          sb_on = 0;

  always #5 clk = ~clk;

  wdt_keyed #(.DATA_W(32), .CNT_W(16), .LOAD_RST(LOAD), .POST_CYC(POST), .SRST_CYC(SRST)) uut (
    .clk_i(clk), .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .expire_o(expire)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_en && sb_on && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata == e, t, rdata, e);
    end
  end

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic expect_read(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    addr = a; rd_en = 1; sb_on = 1;
    @(negedge clk);
    @(posedge clk); #1;
    rd_en = 0; sb_on = 0;
  endtask

  task automatic read_raw(input logic [7:0] a, output logic [31:0] v);
    addr = a; rd_en = 1;
    @(negedge clk);
    v = rdata;
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic wait_expire(input int max, output int n, output bit hit);
    n = 0; hit = 0;
    while (n < max && !hit) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (expire) hit = 1;
    end
  endtask

  task automatic key_write(input logic [31:0] d, input string t);
    logic [31:0] v;
    int pc = 0;
    bit first_ok = 1;
    bus_write(8'h48, d);
    for (int i = 0; i < 20; i++) begin
      read_raw(8'h34, v);
      if (v == 32'h10) pc++;
      else begin
        if (i == 0) first_ok = 0;
        break;
      end
    end
    check(first_ok && pc == POST, t, pc, POST);
  endtask

  task automatic check_running(input bit want, input string t);
    logic [31:0] a, b;
    read_raw(8'h28, a);
    repeat (3) @(posedge clk);
    #1;
    read_raw(8'h28, b);
    check((a != b) == want, t, (a != b), want);
  endtask

  task automatic do_srst(input string t);
    logic [31:0] v;
    int zeros = 1;
    bus_write(8'h10, 32'h2);
    expect_read(8'h14, 32'h0, t);
    for (int i = 0; i < 50; i++) begin
      read_raw(8'h14, v);
      if (v[0]) break;
      zeros++;
    end
    check(zeros == SRST, t, zeros, SRST);
    expect_read(8'h28, cur_load - 1, t);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int n;
    bit hit;
    logic [31:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1;

    // R1: armed from reset
    wait_expire(200, n, hit);
    check(hit && n == LOAD + 1, "R1 first expiry", n, LOAD + 1);
    // R2: periodic reload
    wait_expire(200, n, hit);
    check(hit && n == LOAD + 1, "R2 period", n, LOAD + 1);
    #1;
    expect_read(8'h14, 32'h1, "R7 done after reset");
    expect_read(8'h34, 32'h0, "R4 idle pending");
    expect_read(8'h2C, LOAD, "R8 load reset value");

    // R8: new load used by re-arm and reload
    bus_write(8'h2C, 32'd20);
    cur_load = 20;
    expect_read(8'h2C, 32'd20, "R8 load write");
    do_srst("R7 soft reset");
    wait_expire(200, n, hit);
    wait_expire(200, n, hit);
    check(hit && n == 21, "R8 period from load", n, 21);

    // R3/R4: keyed disable
    #1;
    key_write(32'hAAAA, "R4 pending first key");
    key_write(32'h5555, "R4 pending second key");
    check_running(0, "R3 counter frozen (R9 read)");
    wait_expire(100, n, hit);
    check(!hit, "R3 no expiry while stopped", hit, 0);

    // R7: soft reset re-arms
    #1;
    do_srst("R7 rearm");
    wait_expire(100, n, hit);
    check(hit, "R7 expiry after rearm", hit, 1);

    // R6: wrong sequences
    #1;
    key_write(32'hAAAA, "R6 a");
    key_write(32'h1234, "R6 bad");
    key_write(32'h5555, "R6 b");
    check_running(1, "R6 bad word resets sequence");
    key_write(32'h5555, "R6 lone b");
    check_running(1, "R6 lone second key");
    key_write(32'hAAAA, "R6 a1");
    key_write(32'hAAAA, "R6 a2");
    key_write(32'h5555, "R6 b2");
    check_running(0, "R6 repeated first key");
    do_srst("R7 rearm 2");

    // R5: write during pending dropped
    bus_write(8'h48, 32'hAAAA);
    bus_write(8'h48, 32'h5555);
    for (int i = 0; i < 20; i++) begin
      read_raw(8'h34, v);
      if (!v[4]) break;
    end
    check_running(1, "R5 write while pending ignored");
    key_write(32'h5555, "R5 b");
    check_running(0, "R5 first key kept");
    do_srst("R7 rearm 3");

    summary();
    $finish;
  end
endmodule